// File: doc/BRIEF.md
# Glitch-Free Reconfigurable PWM Channel Core

This block is the timing core of a single pulse-width-modulated output. A prescale counter divides the input clock into a tick. A period counter advances once per tick and sets the length of each period. The output is driven high for a programmed number of ticks at the start of every period. Three 16-bit settings control it: the prescale limit, the period limit and the high length in ticks. These settings are presented on shadow inputs and are never copied into the running configuration in the middle of a period.

A one-cycle update request marks the shadow inputs as pending. The core copies them into its working configuration at the next period boundary and pulses an acknowledge. Until that acknowledge, the shadow inputs must be held steady. Clearing the enable level also acts only at a period boundary. The period in progress runs to its end, the output then stays low, and a one-cycle done pulse is given. The output is a flop, so it never carries combinational glitches. Only the active-high sense is provided.

Top module: `pwm_chan_core`

## Requirements
- R1: One period lasts (P+1)*(D+1) clock cycles, where P is the prescale setting and D is the period setting. A new period follows immediately while the channel stays enabled. With P=0 and D=0 every cycle is a full period.
- R2: In each period the output is high for the first H*(P+1) cycles and low for the rest, where H is the high-length setting. If H is greater than D, the output is high for the whole period. If H is 0, it is low for the whole period.
- R3: A pulse on update_i marks the shadow inputs as pending, and the period already running completes with the old settings. The shadow inputs are sampled and take effect at the next boundary, and update_ack_o is high for exactly the first cycle of that new period.
- R4: If the shadow inputs change without an update request, the output keeps the waveform of the running configuration in every later period, and update_ack_o stays low.
- R5: When enable_i is low in the last cycle of a period, that period completes unchanged. From the next cycle the output is low and stays low while enable_i stays low, and disable_done_o is high for exactly that first idle cycle.
- R6: If enable_i is low only in cycles that are not the last of a period, the output is not interrupted and disable_done_o stays low.
- R7: When enable_i is high while the channel is idle, the shadow inputs are loaded at that clock edge and period cycle 0 is the very next cycle. Any request made while idle is absorbed without an acknowledge.
- R8: After reset the output, update_ack_o and disable_done_o are low, and they stay low while enable_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Run level, sampled at period boundaries and while idle |
| update_i | input | 1 | One-cycle request to commit the shadow inputs |
| prediv_i | input | FIELD_W | Shadow prescale limit P |
| period_div_i | input | FIELD_W | Shadow period limit D |
| high_dur_i | input | FIELD_W | Shadow high length H, in ticks |
| pwm_o | output | 1 | Registered PWM output, active high |
| update_ack_o | output | 1 | One-cycle pulse when pending settings are committed |
| disable_done_o | output | 1 | One-cycle pulse when the channel has stopped |

## Verification
The hardest state to reach is a request or an enable change that lands in the middle of a period, away from the boundary. To show the running period is not disturbed, the bench needs a known phase. Each scenario therefore starts from reset and enables the channel at a known negative edge, so the bench can count the period phase exactly. It changes the shadow inputs, pulses the request or drops enable at a chosen interior phase, then compares every remaining cycle of the old period and the whole of the next period against a waveform computed from the settings.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } chan_st_e;

   localparam int MIN_FIELD_W = 1;
   localparam int MAX_FIELD_W = 32;
endpackage

// File: rtl/pwm_chan_prediv.sv
module pwm_chan_prediv #(
   parameter int FIELD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [FIELD_W-1:0] limit,
   output logic               tick
);
   logic [FIELD_W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pwm_chan_period.sv
module pwm_chan_period #(
   parameter int FIELD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic [FIELD_W-1:0] limit,
   output logic [FIELD_W-1:0] cnt_nxt,
   output logic               wrap
);
   logic [FIELD_W-1:0] cnt_q;

   assign wrap = tick && (cnt_q == limit);

   always_comb begin
      if (!run || wrap)
         cnt_nxt = '0;
      else if (tick)
         cnt_nxt = cnt_q + 1'b1;
      else
         cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
   import pwm_chan_pkg::*;
#(
   parameter int FIELD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               upd_req,
   input  logic [FIELD_W-1:0] pre_in,
   input  logic [FIELD_W-1:0] div_in,
   input  logic [FIELD_W-1:0] hi_in,
   input  logic               wrap,
   input  logic [FIELD_W-1:0] per_nxt,
   output logic               run,
   output logic [FIELD_W-1:0] pre_q,
   output logic [FIELD_W-1:0] div_q,
   output logic [FIELD_W-1:0] hi_q,
   output logic               pwm_q,
   output logic               ack_q,
   output logic               done_q
);
   chan_st_e           st_q, st_nxt;
   logic               pend_q, pend_nxt;
   logic               start, stop, commit, load;
   logic [FIELD_W-1:0] pre_nxt, div_nxt, hi_nxt;

   always_comb begin
      start  = (st_q == ST_IDLE) && enable;
      stop   = (st_q == ST_RUN) && wrap && !enable;
      commit = (st_q == ST_RUN) && wrap && enable && (pend_q || upd_req);
      load   = start || commit;

      st_nxt = st_q;
      if (start)
         st_nxt = ST_RUN;
      else if (stop)
         st_nxt = ST_IDLE;

      pend_nxt = load ? 1'b0 : (pend_q || upd_req);

      pre_nxt = load ? pre_in : pre_q;
      div_nxt = load ? div_in : div_q;
      hi_nxt  = load ? hi_in  : hi_q;
   end

   assign run = (st_q == ST_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pend_q <= 1'b0;
         pre_q  <= '0;
         div_q  <= '0;
         hi_q   <= '0;
         pwm_q  <= 1'b0;
         ack_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_nxt;
         pend_q <= pend_nxt;
         pre_q  <= pre_nxt;
         div_q  <= div_nxt;
         hi_q   <= hi_nxt;
         pwm_q  <= (st_nxt == ST_RUN) && (per_nxt < hi_nxt);
         ack_q  <= commit;
         done_q <= stop;
      end
   end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
   import pwm_chan_pkg::*;
#(
   parameter int FIELD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable_i,
   input  logic               update_i,
   input  logic [FIELD_W-1:0] prediv_i,
   input  logic [FIELD_W-1:0] period_div_i,
   input  logic [FIELD_W-1:0] high_dur_i,
   output logic               pwm_o,
   output logic               update_ack_o,
   output logic               disable_done_o
);
   generate
      if (FIELD_W < MIN_FIELD_W || FIELD_W > MAX_FIELD_W) begin : g_bad_width
         $error("pwm_chan_core: FIELD_W out of supported range");
      end
   endgenerate

   logic               run_w, tick_w, wrap_w;
   logic [FIELD_W-1:0] pre_w, div_w, hi_w, per_nxt_w;

   pwm_chan_prediv #(.FIELD_W(FIELD_W)) u_prediv (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_w),
      .limit (pre_w),
      .tick  (tick_w)
   );

   pwm_chan_period #(.FIELD_W(FIELD_W)) u_period (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_w),
      .tick    (tick_w),
      .limit   (div_w),
      .cnt_nxt (per_nxt_w),
      .wrap    (wrap_w)
   );

   pwm_chan_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable_i),
      .upd_req (update_i),
      .pre_in  (prediv_i),
      .div_in  (period_div_i),
      .hi_in   (high_dur_i),
      .wrap    (wrap_w),
      .per_nxt (per_nxt_w),
      .run     (run_w),
      .pre_q   (pre_w),
      .div_q   (div_w),
      .hi_q    (hi_w),
      .pwm_q   (pwm_o),
      .ack_q   (update_ack_o),
      .done_q  (disable_done_o)
   );
endmodule

// File: rtl/pwm_chan_core_chk.sv
module pwm_chan_core_chk #(
   parameter int FIELD_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               enable_i,
   input logic               pwm_o,
   input logic               update_ack_o,
   input logic               disable_done_o,
   input logic               run_w,
   input logic               wrap_w,
   input logic [FIELD_W-1:0] pre_w,
   input logic [FIELD_W-1:0] div_w,
   input logic [FIELD_W-1:0] hi_w
);
   // R5: output is low in the cycle the stop is reported
   a_r5_done_low : assert property (@(posedge clk) disable iff (!rst_n)
      disable_done_o |-> !pwm_o);

   // R5: a stop is reported only after a boundary with enable low
   a_r5_done_cause : assert property (@(posedge clk) disable iff (!rst_n)
      disable_done_o |-> ($past(wrap_w) && !$past(enable_i)));

   // R8: output never high while idle
   a_r8_idle_low : assert property (@(posedge clk) disable iff (!rst_n)
      !run_w |-> !pwm_o);

   // R3: acknowledge only right after a period boundary
   a_r3_ack_at_boundary : assert property (@(posedge clk) disable iff (!rst_n)
      update_ack_o |-> $past(wrap_w));

   // R3: working settings do not move inside a period
   a_r3_cfg_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (run_w && !wrap_w) |=> $stable({pre_w, div_w, hi_w}));

   // R5: commit and stop never reported together
   a_r5_no_ack_on_stop : assert property (@(posedge clk) disable iff (!rst_n)
      !(update_ack_o && disable_done_o));
endmodule

bind pwm_chan_core pwm_chan_core_chk #(.FIELD_W(FIELD_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enable_i       (enable_i),
   .pwm_o          (pwm_o),
   .update_ack_o   (update_ack_o),
   .disable_done_o (disable_done_o),
   .run_w          (run_w),
   .wrap_w         (wrap_w),
   .pre_w          (pre_w),
   .div_w          (div_w),
   .hi_w           (hi_w)
);

// File: tb/pwm_chan_core_tb.sv
module pwm_chan_core_tb;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          upd = 1'b0;
   logic [FW-1:0] pre = '0;
   logic [FW-1:0] dv = '0;
   logic [FW-1:0] hi = '0;
   logic          pwm, ack, done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   pwm_chan_core #(.FIELD_W(FW)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .enable_i       (en),
      .update_i       (upd),
      .prediv_i       (pre),
      .period_div_i   (dv),
      .high_dur_i     (hi),
      .pwm_o          (pwm),
      .update_ack_o   (ack),
      .disable_done_o (done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; en = 1'b0; upd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Expected waveform: high iff (phase / (p+1)) < h; pulses must stay low.
   task automatic expect_wave(input int p, input int d, input int h,
                              input int ph0, input int n, input string req);
      int bad_at = -1;
      int act = 0;
      int exp = 0;
      for (int i = 0; i < n; i++) begin
         int ph;
         int e;
         @(negedge clk);
         ph = (ph0 + i) % ((p + 1) * (d + 1));
         e  = ((ph / (p + 1)) < h) ? 1 : 0;
         if (bad_at < 0 && (int'(pwm) != e || ack || done)) begin
            bad_at = i;
            act = int'(pwm) * 4 + int'(ack) * 2 + int'(done);
            exp = e * 4;
         end
      end
      chk(bad_at < 0, req, act, exp);
   endtask

   task automatic start_run(input int p, input int d, input int h);
      @(negedge clk);
      pre = FW'(p); dv = FW'(d); hi = FW'(h);
      en = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(pwm == 1'b0, "R8 pwm", int'(pwm), 0);
      end
      chk(ack == 1'b0, "R8 ack", int'(ack), 0);
      chk(done == 1'b0, "R8 done", int'(done), 0);
   endtask

   task automatic t_basic();
      do_reset();
      start_run(1, 4, 2);
      expect_wave(1, 4, 2, 0, 30, "R1 R2 basic");
      do_reset();
      start_run(2, 2, 1);
      expect_wave(2, 2, 1, 0, 27, "R1 R2 second pattern");
   endtask

   task automatic t_extremes();
      do_reset();
      start_run(2, 3, 0);
      expect_wave(2, 3, 0, 0, 24, "R2 zero high");
      do_reset();
      start_run(1, 3, 4);
      expect_wave(1, 3, 4, 0, 16, "R2 high equals count");
      do_reset();
      start_run(0, 3, 9);
      expect_wave(0, 3, 9, 0, 12, "R2 high exceeds count");
   endtask

   task automatic t_update();
      do_reset();
      start_run(1, 4, 2);
      expect_wave(1, 4, 2, 0, 3, "R3 before request");
      pre = FW'(0); dv = FW'(2); hi = FW'(1);
      upd = 1'b1;
      expect_wave(1, 4, 2, 3, 1, "R3 request cycle");
      upd = 1'b0;
      expect_wave(1, 4, 2, 4, 6, "R3 old period completes");
      @(negedge clk);
      chk(ack == 1'b1, "R3 ack in first new cycle", int'(ack), 1);
      chk(pwm == 1'b1, "R3 new high at phase 0", int'(pwm), 1);
      expect_wave(0, 2, 1, 1, 8, "R3 new settings, single ack");
   endtask

   task automatic t_no_request();
      do_reset();
      start_run(1, 4, 2);
      expect_wave(1, 4, 2, 0, 5, "R4 before change");
      pre = FW'(0); dv = FW'(1); hi = FW'(0);
      expect_wave(1, 4, 2, 5, 25, "R4 unchanged waveform");
   endtask

   task automatic t_disable();
      do_reset();
      start_run(1, 4, 2);
      expect_wave(1, 4, 2, 0, 2, "R5 before disable");
      en = 1'b0;
      expect_wave(1, 4, 2, 2, 8, "R5 period completes");
      @(negedge clk);
      chk(done == 1'b1, "R5 done pulse", int'(done), 1);
      chk(pwm == 1'b0, "R5 low after stop", int'(pwm), 0);
      expect_wave(0, 0, 0, 0, 10, "R5 stays low, single pulse");
   endtask

   task automatic t_glitch();
      do_reset();
      start_run(1, 4, 2);
      expect_wave(1, 4, 2, 0, 4, "R6 before drop");
      en = 1'b0;
      expect_wave(1, 4, 2, 4, 2, "R6 during drop");
      en = 1'b1;
      expect_wave(1, 4, 2, 6, 14, "R6 uninterrupted");
   endtask

   task automatic t_start_pending();
      do_reset();
      pre = FW'(1); dv = FW'(4); hi = FW'(2);
      @(negedge clk);
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      chk(ack == 1'b0, "R7 no ack while idle", int'(ack), 0);
      start_run(1, 4, 3);
      expect_wave(1, 4, 3, 0, 20, "R7 start loads at once, no ack");
   endtask

   task automatic t_minimum();
      do_reset();
      start_run(0, 0, 1);
      expect_wave(0, 0, 1, 0, 5, "R1 one-cycle period");
      en = 1'b0;
      @(negedge clk);
      chk(done == 1'b1, "R5 stop at one-cycle boundary", int'(done), 1);
      chk(pwm == 1'b0, "R5 low after one-cycle stop", int'(pwm), 0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_extremes();
      t_update();
      t_no_request();
      t_disable();
      t_glitch();
      t_start_pending();
      t_minimum();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule